// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This unit forms the 12-bit data-memory address for an instruction and serves the read or write that follows. Data space is sixteen banks of 256 bytes. A four-bit bank number, held in an eight-bit bank register that a load-bank operation writes, supplies the upper address bits. The 8-bit operand from the instruction supplies the lower bits.

Each access selects one of three address modes. The banked mode joins the bank register and the operand. The window mode ignores the bank register. It maps the operand onto a flat 256-byte window made from two separate regions: the bottom 96 bytes of bank 0 and the top 160 bytes of bank 15. The direct mode takes a complete 12-bit address from the instruction, as a register-to-register move needs.

Addresses from 0xF60 to 0xFFF are passed to an external special-function register file. The lower part of the space goes to a general-purpose RAM whose number of banks is a parameter. A bank that is not implemented reads as zero, and writes to it are dropped.

Top module: `dmem_bank_unit`

## Requirements
- R1: In banked mode (`acc_mode` = 2'b01) the effective address is the bank number in bits [11:8] and `op_addr` in bits [7:0].
- R2: A load-bank operation (`bsr_load` = 1) stores `bsr_load_val[3:0]` at the next rising edge. `bsr_q` always shows bits [7:4] as zero, whatever value was loaded.
- R3: In window mode (`acc_mode` = 2'b00), operands 0x00 to 0x5F address 0x000 to 0x05F, whatever the bank register holds.
- R4: In window mode, operands 0x60 to 0xFF address 0xF60 to 0xFFF. Operand 0x5F is followed directly by address 0xF60.
- R5: In direct mode (`acc_mode` = 2'b10 or 2'b11), the effective address equals `full_addr`, and the bank register has no effect.
- R6: An access below 0xF60 whose bank number is at or above `NUM_GP_BANKS` returns `rdata` = 0. A write to it changes neither the RAM nor the special-function port.
- R7: An access to 0xF60 to 0xFFF asserts `sfr_sel`, drives `sfr_addr` with the low address byte, and returns `sfr_rdata` on `rdata`. A write asserts `sfr_we` and leaves the RAM untouched.
- R8: A RAM write takes effect at the rising edge. Read data is combinational, so a read of the same address in the next cycle returns the new value.
- R9: A synchronous active-low reset clears the bank register to 0x00.
- R10: When a load-bank operation and a banked access occur in the same cycle, the access uses the old bank. The new bank applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bsr_load | input | 1 | Load-bank operation strobe |
| bsr_load_val | input | 8 | Immediate value for the bank register |
| bsr_q | output | 8 | Bank register read value, upper nibble zero |
| acc_en | input | 1 | Data access valid this cycle |
| acc_we | input | 1 | Access is a write |
| acc_mode | input | 2 | 00 window, 01 banked, 10/11 direct |
| op_addr | input | 8 | Operand address from the instruction |
| full_addr | input | 12 | Full address for direct mode |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| eff_addr | output | 12 | Effective 12-bit address |
| sfr_sel | output | 1 | Special-function register access |
| sfr_we | output | 1 | Special-function register write |
| sfr_addr | output | 8 | Special-function register offset |
| sfr_wdata | output | 8 | Special-function register write data |
| sfr_rdata | input | 8 | Special-function register read data |

## Verification
The only internal state that can go wrong is the bank register and the RAM contents. A wrong bank value appears on `bsr_q` and `eff_addr` in the very cycle after the load. Bad RAM state or a wrong route shows up on `rdata` at the first read of the affected location. A dropped or misrouted write is therefore detected by writing and then reading back, both through the banked path and through an aliased direct address. The same-cycle load case is observed in `eff_addr` during the access itself.

// File: rtl/dmem_bank_pkg.sv
// Shared constants and types for the banked data memory address unit.
// Assumes a 12-bit data space split into 256-byte banks.
package dmem_bank_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 8;
    localparam int OFS_W  = 8;
    localparam int BANK_W = ADDR_W - OFS_W;
    localparam int BSR_W  = 8;

    // first operand value that lands in the high window region
    localparam logic [OFS_W-1:0]  WIN_SPLIT = 8'h60;
    // first address served by the special-function register port
    localparam logic [ADDR_W-1:0] SFR_BASE  = 12'hF60;
    localparam logic [BANK_W-1:0] BANK_LOW  = '0;
    localparam logic [BANK_W-1:0] BANK_HIGH = '1;

    typedef enum logic [1:0] {
        AM_WINDOW  = 2'b00,
        AM_BANKED  = 2'b01,
        AM_DIRECT  = 2'b10,
        AM_DIRECT2 = 2'b11
    } acc_mode_e;
endpackage

// File: rtl/dmem_bank_sel.sv
// Bank select register: holds the bank number loaded by the load-bank
// operation. Only the low BANK_W bits are stored; the rest read as zero.
// Assumes synchronous active-low reset.
module dmem_bank_sel #(
    parameter int BANK_W = 4,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [REG_W-1:0]  load_val,
    output logic [BANK_W-1:0] bank,
    output logic [REG_W-1:0]  reg_q
);
    localparam int PAD_W = REG_W - BANK_W;

    logic [BANK_W-1:0] bank_q;

    // capture the immediate bank number on a load-bank operation
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= '0;
        else if (load)
            bank_q <= load_val[BANK_W-1:0];
    end

    assign bank  = bank_q;
    assign reg_q = {{PAD_W{1'b0}}, bank_q};

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> reg_q == {{PAD_W{1'b0}}, $past(load_val[BANK_W-1:0])});

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !load) |=> $stable(reg_q));

    assert_reset_R9: assert property (@(posedge clk)
        !rst_n |=> reg_q == '0);
endmodule

// File: rtl/dmem_addr_form.sv
// Effective address former: combines the mode, operand, full address and
// bank number into a 12-bit data address. Purely combinational.
module dmem_addr_form
    import dmem_bank_pkg::*;
(
    input  acc_mode_e          mode,
    input  logic [OFS_W-1:0]   op,
    input  logic [ADDR_W-1:0]  full,
    input  logic [BANK_W-1:0]  bank,
    output logic [ADDR_W-1:0]  eff
);
    logic [BANK_W-1:0] win_bank;

    // pick which end of the space the window operand falls into
    always_comb begin
        win_bank = (op < WIN_SPLIT) ? BANK_LOW : BANK_HIGH;
    end

    // select the address source for the requested mode
    always_comb begin
        case (mode)
            AM_WINDOW: eff = {win_bank, op};
            AM_BANKED: eff = {bank, op};
            default:   eff = full;
        endcase
    end
endmodule

// File: rtl/dmem_gp_ram.sv
// General-purpose data RAM: NUM_BANKS x 256 bytes, synchronous write,
// combinational read. No reset of contents.
module dmem_gp_ram #(
    parameter int NUM_BANKS = 2,
    parameter int DATA_W    = 8,
    parameter int AW        = $clog2(NUM_BANKS * 256)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = NUM_BANKS * 256;

    logic [DATA_W-1:0] mem [DEPTH];

    // store write data at the rising edge
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

    assert_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(addr)] == $past(wdata));
endmodule

// File: rtl/dmem_bank_unit.sv
// Banked data memory address unit (top). Forms the effective address,
// routes it to the general-purpose RAM, the special-function register
// port or the unimplemented space (reads zero, writes dropped).
// Assumes 1 <= NUM_GP_BANKS <= 16.
module dmem_bank_unit
    import dmem_bank_pkg::*;
#(
    parameter int NUM_GP_BANKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bsr_load,
    input  logic [7:0]        bsr_load_val,
    output logic [7:0]        bsr_q,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [1:0]        acc_mode,
    input  logic [7:0]        op_addr,
    input  logic [11:0]       full_addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [11:0]       eff_addr,
    output logic              sfr_sel,
    output logic              sfr_we,
    output logic [7:0]        sfr_addr,
    output logic [7:0]        sfr_wdata,
    input  logic [7:0]        sfr_rdata
);
    localparam int RAM_AW = $clog2(NUM_GP_BANKS * 256);
    localparam logic [BANK_W:0] GP_LIMIT = (BANK_W+1)'(NUM_GP_BANKS);

    logic [BANK_W-1:0] bank;
    logic [ADDR_W-1:0] eff;
    logic              is_sfr;
    logic              is_gp;
    logic              ram_we;
    logic [DATA_W-1:0] ram_rdata;

    dmem_bank_sel #(.BANK_W(BANK_W), .REG_W(BSR_W)) u_bank_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (bsr_load),
        .load_val (bsr_load_val),
        .bank     (bank),
        .reg_q    (bsr_q)
    );

    dmem_addr_form u_addr_form (
        .mode (acc_mode_e'(acc_mode)),
        .op   (op_addr),
        .full (full_addr),
        .bank (bank),
        .eff  (eff)
    );

    // classify the effective address into SFR, RAM or unimplemented space
    always_comb begin
        is_sfr = (eff >= SFR_BASE);
        is_gp  = !is_sfr && ({1'b0, eff[ADDR_W-1:OFS_W]} < GP_LIMIT);
    end

    assign ram_we = acc_en && acc_we && is_gp;

    dmem_gp_ram #(.NUM_BANKS(NUM_GP_BANKS), .DATA_W(DATA_W), .AW(RAM_AW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .addr  (eff[RAM_AW-1:0]),
        .wdata (wdata),
        .rdata (ram_rdata)
    );

    // steer read data from the selected target, zero for unimplemented space
    always_comb begin
        if (is_sfr)
            rdata = sfr_rdata;
        else if (is_gp)
            rdata = ram_rdata;
        else
            rdata = '0;
    end

    assign eff_addr  = eff;
    assign sfr_sel   = acc_en && is_sfr;
    assign sfr_we    = acc_en && acc_we && is_sfr;
    assign sfr_addr  = eff[OFS_W-1:0];
    assign sfr_wdata = wdata;

    assert_sfr_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && eff_addr >= SFR_BASE) |-> (sfr_sel && !ram_we && sfr_addr == eff_addr[7:0]));

    assert_unimpl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && eff_addr < SFR_BASE && {1'b0, eff_addr[11:8]} >= GP_LIMIT)
        |-> (rdata == '0 && !ram_we && !sfr_we && !sfr_sel));

    assert_old_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode == AM_BANKED) |-> (eff_addr[11:8] == bsr_q[3:0]));

    assert_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode == AM_WINDOW) |->
        (eff_addr[11:8] == (op_addr < WIN_SPLIT ? BANK_LOW : BANK_HIGH)));
endmodule

// File: tb/dmem_bank_unit_bench.sv
// Directed bench for dmem_bank_unit: one task per scenario.
module dmem_bank_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bsr_load = 1'b0;
    logic [7:0]  bsr_load_val = '0;
    logic [7:0]  bsr_q;
    logic        acc_en = 1'b0;
    logic        acc_we = 1'b0;
    logic [1:0]  acc_mode = 2'b00;
    logic [7:0]  op_addr = '0;
    logic [11:0] full_addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [11:0] eff_addr;
    logic        sfr_sel;
    logic        sfr_we;
    logic [7:0]  sfr_addr;
    logic [7:0]  sfr_wdata;
    logic [7:0]  sfr_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [1:0] M_WIN = 2'b00;
    localparam logic [1:0] M_BNK = 2'b01;
    localparam logic [1:0] M_DIR = 2'b10;

    always #(CLK_PERIOD/2) clk = ~clk;

    // simple special-function register file model: read data derived from offset
    assign sfr_rdata = sfr_addr ^ 8'hA5;

    dmem_bank_unit #(.NUM_GP_BANKS(2)) u_dmem_bank_unit (
        .clk(clk), .rst_n(rst_n), .bsr_load(bsr_load), .bsr_load_val(bsr_load_val),
        .bsr_q(bsr_q), .acc_en(acc_en), .acc_we(acc_we), .acc_mode(acc_mode),
        .op_addr(op_addr), .full_addr(full_addr), .wdata(wdata), .rdata(rdata),
        .eff_addr(eff_addr), .sfr_sel(sfr_sel), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    task automatic chk(input string req, input string what,
                       input logic [11:0] act, input logic [11:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive an access (called at a falling edge); outputs settle after #1
    task automatic put(input logic [1:0] m, input logic [7:0] op,
                       input logic [11:0] fa, input logic we, input logic [7:0] wd);
        acc_en = 1'b1; acc_mode = m; op_addr = op; full_addr = fa;
        acc_we = we; wdata = wd;
        #1;
    endtask

    // pass one rising edge and return to idle at the next falling edge
    task automatic tick();
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0; bsr_load = 1'b0;
    endtask

    task automatic set_bank(input logic [7:0] v);
        bsr_load = 1'b1; bsr_load_val = v;
        tick();
    endtask

    task automatic t_reset();
        chk("R9", "bsr after reset", 12'(bsr_q), 12'h000);
        set_bank(8'h03);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9", "bsr after mid-run reset", 12'(bsr_q), 12'h000);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_bank_load();
        set_bank(8'hA7);
        chk("R2", "upper bits dropped", 12'(bsr_q), 12'h007);
        set_bank(8'hF0);
        chk("R2", "upper-only load", 12'(bsr_q), 12'h000);
        set_bank(8'h0E);
        chk("R2", "bank 14 load", 12'(bsr_q), 12'h00E);
    endtask

    task automatic t_banked();
        set_bank(8'h01);
        put(M_BNK, 8'h34, 12'h000, 1'b0, 8'h00);
        chk("R1", "banked address", eff_addr, 12'h134);
        tick();
        set_bank(8'h0C);
        put(M_BNK, 8'hFE, 12'h000, 1'b0, 8'h00);
        chk("R1", "banked address bank 12", eff_addr, 12'hCFE);
        tick();
    endtask

    task automatic t_window();
        set_bank(8'h01);
        put(M_WIN, 8'h00, 12'h000, 1'b0, 8'h00);
        chk("R3", "window 0x00", eff_addr, 12'h000);
        put(M_WIN, 8'h5F, 12'h000, 1'b0, 8'h00);
        chk("R3", "window 0x5F", eff_addr, 12'h05F);
        put(M_WIN, 8'h60, 12'h000, 1'b0, 8'h00);
        chk("R4", "window 0x60", eff_addr, 12'hF60);
        put(M_WIN, 8'hFF, 12'h000, 1'b0, 8'h00);
        chk("R4", "window 0xFF", eff_addr, 12'hFFF);
        tick();
    endtask

    task automatic t_direct();
        set_bank(8'h07);
        put(M_DIR, 8'h55, 12'h1AB, 1'b0, 8'h00);
        chk("R5", "direct address", eff_addr, 12'h1AB);
        put(2'b11, 8'h55, 12'h02C, 1'b0, 8'h00);
        chk("R5", "direct alt code", eff_addr, 12'h02C);
        tick();
    endtask

    task automatic t_ram();
        put(M_DIR, 8'h00, 12'h010, 1'b1, 8'h5A);
        tick();
        put(M_DIR, 8'h00, 12'h010, 1'b0, 8'h00);
        chk("R8", "read after write bank0", 12'(rdata), 12'h05A);
        tick();
        set_bank(8'h01);
        put(M_BNK, 8'h10, 12'h000, 1'b1, 8'hC3);
        tick();
        put(M_BNK, 8'h10, 12'h000, 1'b0, 8'h00);
        chk("R8", "banked read after write", 12'(rdata), 12'h0C3);
        put(M_WIN, 8'h10, 12'h000, 1'b0, 8'h00);
        chk("R8", "bank0 unchanged via window", 12'(rdata), 12'h05A);
        tick();
    endtask

    task automatic t_unimpl();
        put(M_DIR, 8'h00, 12'h110, 1'b1, 8'h3C);
        tick();
        set_bank(8'h05);
        put(M_BNK, 8'h10, 12'h000, 1'b1, 8'h77);
        chk("R6", "no sfr write", 12'(sfr_we), 12'h000);
        tick();
        put(M_BNK, 8'h10, 12'h000, 1'b0, 8'h00);
        chk("R6", "unimplemented read", 12'(rdata), 12'h000);
        put(M_DIR, 8'h00, 12'h110, 1'b0, 8'h00);
        chk("R6", "aliased RAM untouched", 12'(rdata), 12'h03C);
        put(M_DIR, 8'h00, 12'hF20, 1'b0, 8'h00);
        chk("R6", "bank 15 low read", 12'(rdata), 12'h000);
        tick();
    endtask

    task automatic t_sfr();
        put(M_DIR, 8'h00, 12'h180, 1'b1, 8'h11);
        tick();
        put(M_WIN, 8'h80, 12'h000, 1'b0, 8'h00);
        chk("R7", "sfr select", 12'(sfr_sel), 12'h001);
        chk("R7", "sfr offset", 12'(sfr_addr), 12'h080);
        chk("R7", "sfr read data", 12'(rdata), 12'(8'h80 ^ 8'hA5));
        put(M_WIN, 8'h80, 12'h000, 1'b1, 8'hEE);
        chk("R7", "sfr write strobe", 12'(sfr_we), 12'h001);
        chk("R7", "sfr write data", 12'(sfr_wdata), 12'h0EE);
        tick();
        put(M_DIR, 8'h00, 12'h180, 1'b0, 8'h00);
        chk("R7", "RAM untouched by sfr write", 12'(rdata), 12'h011);
        tick();
    endtask

    task automatic t_same_cycle();
        set_bank(8'h00);
        bsr_load = 1'b1; bsr_load_val = 8'h01;
        put(M_BNK, 8'h22, 12'h000, 1'b1, 8'h99);
        chk("R10", "old bank used", eff_addr, 12'h022);
        tick();
        chk("R10", "new bank applied", 12'(bsr_q), 12'h001);
        put(M_BNK, 8'h22, 12'h000, 1'b1, 8'h44);
        chk("R10", "next cycle address", eff_addr, 12'h122);
        tick();
        put(M_DIR, 8'h00, 12'h022, 1'b0, 8'h00);
        chk("R10", "write went to old bank", 12'(rdata), 12'h099);
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bank_load();
        t_banked();
        t_window();
        t_direct();
        t_ram();
        t_unimpl();
        t_sfr();
        t_same_cycle();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule